// File: doc/BRIEF.md
# NOR Flash Command Interface

This block is a synthesizable model of a parallel NOR flash that follows the classic unlock-and-command protocol. A host on a simple synchronous bus cannot store into the array directly. Every write is decoded as an address/data pair by a command state machine. An unlock pair followed by a command byte selects one of several operations: program a word, erase one sector, erase the whole array, enter autoselect identification or enter a persistent bypass mode. A separate single-write sequence enters a query mode that returns a fixed parameter table.

Reads return one of four sources, depending on the current mode: array words, identifier words, query table bytes or a status byte. While a program command is pending or an erase is busy, reads return the status byte. Each status read flips bit 6 so that software can poll for completion. Erase time is a parameterized number of clock cycles.

Command addresses are device-word addresses. The bus carries byte addresses, which the block shifts right by log2(DATA_W/8). With the default 16-bit word, word 0x555 is bus address 0xAAA, word 0x2AA is 0x554 and word 0x55 is 0xAA. The array is indexed by the low bits of the word address.

Top module: `norFlashTop`

## Requirements
- R1: After reset the block is in read mode, busy is low, every array word reads 0xFFFF and the status byte is 0x00.
- R2: A command needs 0xAA at word 0x555 and then 0x55 at word 0x2AA (byte addresses 0xAAA and 0x554). A wrong address or wrong data at either step returns the block to read mode, and a later command byte then has no effect on the array.
- R3: After unlock and 0xA0 at word 0x555, the next write stores the bitwise AND of the old word and the written data at its address, so bits only go from 1 to 0.
- R4: After unlock and 0x90, reads at word offsets 0 and 1 (the low 8 bits of the word address) return the two identifier parameters, and offset 2 returns 0. Offsets 0x0E and 0x0F return the extended identifiers when EXT_ID_EN is set. Every other offset returns array data.
- R5: Writing 0x98 at word 0x55 from read mode or from autoselect enters query mode. There, offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59, offset 0x13 returns 0x02 and offset 0x27 returns log2 of the array size in bytes. Offsets at or beyond 0x31 return 0. Any write leaves query mode for read mode.
- R6: Data 0xF0 written in any state except the program data cycle and the erase busy period returns the block to read mode and clears bypass. As program data, 0xF0 is stored like any other value.
- R7: After unlock, 0x80, a second unlock and then 0x30 at any address, every word of the aligned SECTOR_WORDS sector holding that address reads 0xFFFF and other sectors keep their contents. Busy is high for exactly SECT_ERASE_CYC cycles.
- R8: The same sequence ending in 0x10 at word 0x555 sets every word to 0xFFFF with busy high for exactly CHIP_ERASE_CYC cycles. Data 0x10 at any other address returns to read mode with no erase.
- R9: Erase start clears status to 0x00. Each status read during busy returns the current status and then inverts bit 6. Writes during busy, 0xF0 included, are ignored. At completion status bit 7 inverts. Status is read back as the low byte while a program command is pending.
- R10: A program data write with bit 7 set leaves status 0x7F. With bit 7 clear it leaves 0xFF.
- R11: 0x20 as the command byte enters bypass mode. There, each command byte is taken at any address without an unlock pair. After a program, or after an erase completes, the block waits for the next command byte. 0x90 followed by 0x00 leaves bypass for read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte address |
| wrData | input | DATA_W | Write data; command bytes use bits 7:0 |
| rdData | output | DATA_W | Read data, registered |
| busy | output | 1 | High while an erase is in progress |

## Verification
Read data is registered. A read strobed in one cycle shows its value on rdData one cycle later, and that is the cycle in which the bench checks it. Status toggling and mode changes from a write take effect on the edge that samples the strobe, so the next access already sees the new mode. Busy rises on the edge that takes the erase command byte and falls SECT_ERASE_CYC or CHIP_ERASE_CYC edges later. The bench counts the falling-edge samples with busy high and compares that count with the parameter. Expected read values go into a queue when the read is issued and are compared exactly one cycle later.

// File: rtl/norFlashPkg.sv
package norFlashPkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNLK1, ST_CMD, ST_PROG, ST_ESET, ST_EUNLK1, ST_ESEL,
    ST_BUSY, ST_AUTO, ST_CFI
  } cmdState_t;

  typedef enum logic [1:0] {RS_ARRAY, RS_STATUS, RS_IDENT, RS_QUERY} rdSel_t;

  typedef struct packed {
    logic   progWr;
    logic   sectErase;
    logic   chipErase;
    logic   statFlip7;
    rdSel_t rdSel;
  } dpCtl_t;

  localparam logic [7:0] CB_UNLOCK0 = 8'hAA;
  localparam logic [7:0] CB_UNLOCK1 = 8'h55;
  localparam logic [7:0] CB_BYPASS  = 8'h20;
  localparam logic [7:0] CB_ERASE   = 8'h80;
  localparam logic [7:0] CB_IDENT   = 8'h90;
  localparam logic [7:0] CB_PROGRAM = 8'hA0;
  localparam logic [7:0] CB_QUERY   = 8'h98;
  localparam logic [7:0] CB_RESET   = 8'hF0;
  localparam logic [7:0] CB_SECTOR  = 8'h30;
  localparam logic [7:0] CB_CHIP    = 8'h10;
  localparam logic [7:0] CB_BYPEXIT = 8'h00;

  localparam int WA_FIRST  = 'h555;
  localparam int WA_SECOND = 'h2AA;
  localparam int WA_QUERY  = 'h55;

endpackage

// File: rtl/norFlashCtrl.sv
module norFlashCtrl
  import norFlashPkg::*;
#(
  parameter int WA_W           = 12,
  parameter int SECT_ERASE_CYC = 20,
  parameter int CHIP_ERASE_CYC = 40
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WA_W-1:0] wa,
  input  logic [7:0]      cmdByte,
  output dpCtl_t          ctl,
  output logic            busy
);
  localparam int MAX_CYC = (CHIP_ERASE_CYC > SECT_ERASE_CYC) ? CHIP_ERASE_CYC : SECT_ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cmdState_t        state, nState;
  logic             bypass, nBypass;
  logic [CNT_W-1:0] busyCnt, nCnt;

  logic atFirst, atSecond, atQuery;
  assign atFirst  = (wa == WA_W'(WA_FIRST));
  assign atSecond = (wa == WA_W'(WA_SECOND));
  assign atQuery  = (wa == WA_W'(WA_QUERY));

  always_comb begin
    nState        = state;
    nBypass       = bypass;
    nCnt          = busyCnt;
    ctl.progWr    = 1'b0;
    ctl.sectErase = 1'b0;
    ctl.chipErase = 1'b0;
    ctl.statFlip7 = 1'b0;
    if (state == ST_BUSY) begin
      if (busyCnt == '0) begin
        ctl.statFlip7 = 1'b1;
        nState        = bypass ? ST_CMD : ST_READ;
      end else begin
        nCnt = busyCnt - 1'b1;
      end
    end else if (wrEn) begin
      nState  = ST_READ;
      nBypass = 1'b0;
      if (state == ST_PROG || cmdByte != CB_RESET) begin
        nBypass = bypass;
        case (state)
          ST_READ: begin
            if (atQuery && cmdByte == CB_QUERY) nState = ST_CFI;
            else if (atFirst && cmdByte == CB_UNLOCK0) nState = ST_UNLK1;
            else nBypass = 1'b0;
          end
          ST_UNLK1, ST_EUNLK1: begin
            if (atSecond && cmdByte == CB_UNLOCK1) nState = (state == ST_UNLK1) ? ST_CMD : ST_ESEL;
            else nBypass = 1'b0;
          end
          ST_CMD: begin
            nBypass = 1'b0;
            if (bypass || atFirst) begin
              nBypass = bypass;
              case (cmdByte)
                CB_BYPASS:  begin nBypass = 1'b1; nState = ST_CMD; end
                CB_ERASE:   nState = ST_ESET;
                CB_IDENT:   nState = ST_AUTO;
                CB_PROGRAM: nState = ST_PROG;
                default:    nBypass = 1'b0;
              endcase
            end
          end
          ST_PROG: begin
            ctl.progWr = 1'b1;
            nState     = bypass ? ST_CMD : ST_READ;
          end
          ST_ESET: begin
            if (atFirst && cmdByte == CB_UNLOCK0) nState = ST_EUNLK1;
            else nBypass = 1'b0;
          end
          ST_ESEL: begin
            if (cmdByte == CB_SECTOR) begin
              ctl.sectErase = 1'b1;
              nState        = ST_BUSY;
              nCnt          = CNT_W'(SECT_ERASE_CYC - 1);
            end else if (cmdByte == CB_CHIP && atFirst) begin
              ctl.chipErase = 1'b1;
              nState        = ST_BUSY;
              nCnt          = CNT_W'(CHIP_ERASE_CYC - 1);
            end else begin
              nBypass = 1'b0;
            end
          end
          ST_AUTO: begin
            if (!(bypass && cmdByte == CB_BYPEXIT) && atQuery && cmdByte == CB_QUERY) nState = ST_CFI;
            else nBypass = 1'b0;
          end
          default: nBypass = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_PROG, ST_BUSY: ctl.rdSel = RS_STATUS;
      ST_AUTO:          ctl.rdSel = RS_IDENT;
      ST_CFI:           ctl.rdSel = RS_QUERY;
      default:          ctl.rdSel = RS_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_READ;
      bypass  <= 1'b0;
      busyCnt <= '0;
    end else begin
      state   <= nState;
      bypass  <= nBypass;
      busyCnt <= nCnt;
    end
  end

  assign busy = (state == ST_BUSY);

  logic [CNT_W:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < (CNT_W+1)'(MAX_CYC))); // R8
  AST_ERASE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sectErase || ctl.chipErase) |=> busy); // R7
  AST_RESET_BYTE_TO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdByte == CB_RESET && state != ST_PROG && state != ST_BUSY)
      |=> (state == ST_READ && !bypass)); // R6
  AST_BYPASS_PROG_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.progWr && bypass) |=> (state == ST_CMD && bypass)); // R11

endmodule

// File: rtl/norFlashData.sv
module norFlashData
  import norFlashPkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int WORDS        = 64,
  parameter int SECTOR_WORDS = 16,
  parameter logic [DATA_W-1:0] ID_MFR  = 'h0001,
  parameter logic [DATA_W-1:0] ID_DEV  = 'h227E,
  parameter logic [DATA_W-1:0] ID_EXT0 = 'h2210,
  parameter logic [DATA_W-1:0] ID_EXT1 = 'h2201,
  parameter bit  EXT_ID_EN     = 1'b1,
  localparam int IDX_W         = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  arrIdx,
  input  logic [7:0]        regOff,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int SECT_SH     = $clog2(SECTOR_WORDS);
  localparam int TOTAL_BYTES = WORDS * DATA_W / 8;
  localparam int SECT_BYTES  = SECTOR_WORDS * DATA_W / 8;
  localparam int NSECT       = WORDS / SECTOR_WORDS;
  localparam int QUERY_LEN   = 'h31;

  logic [DATA_W-1:0] mem [WORDS];
  logic [7:0]        status;
  logic [DATA_W-1:0] rdMux;

  function automatic logic [7:0] queryByte(input logic [7:0] off);
    case (off)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h02;
      8'h27:   return 8'($clog2(TOTAL_BYTES));
      8'h2C:   return 8'h01;
      8'h2D:   return 8'(NSECT - 1);
      8'h2E:   return 8'((NSECT - 1) >> 8);
      8'h2F:   return 8'(SECT_BYTES >> 8);
      8'h30:   return 8'(SECT_BYTES >> 16);
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    rdMux = mem[arrIdx];
    case (ctl.rdSel)
      RS_STATUS: rdMux = DATA_W'(status);
      RS_IDENT: begin
        if (regOff == 8'h00) rdMux = ID_MFR;
        else if (regOff == 8'h01) rdMux = ID_DEV;
        else if (regOff == 8'h02) rdMux = '0;
        else if (EXT_ID_EN && regOff == 8'h0E) rdMux = ID_EXT0;
        else if (EXT_ID_EN && regOff == 8'h0F) rdMux = ID_EXT1;
      end
      RS_QUERY: rdMux = (int'(regOff) < QUERY_LEN) ? DATA_W'(queryByte(regOff)) : '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      status <= 8'h00;
      rdData <= '0;
    end else begin
      if (rdEn) begin
        rdData <= rdMux;
        if (ctl.rdSel == RS_STATUS) status[6] <= ~status[6];
      end
      if (ctl.progWr) begin
        mem[arrIdx] <= mem[arrIdx] & wrData;
        status      <= {~wrData[7], 7'h7F};
      end
      if (ctl.sectErase) begin
        for (int i = 0; i < WORDS; i++)
          if ((i >> SECT_SH) == (int'(arrIdx) >> SECT_SH)) mem[i] <= '1;
        status <= 8'h00;
      end
      if (ctl.chipErase) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        status <= 8'h00;
      end
      if (ctl.statFlip7) status[7] <= ~status[7];
    end
  end

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.progWr |=> ((mem[$past(arrIdx)] & ~$past(wrData)) == '0)); // R3
  AST_ERASE_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sectErase || ctl.chipErase) |=> (status == 8'h00)); // R9
  AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.progWr, ctl.sectErase, ctl.chipErase})); // R7

endmodule

// File: rtl/norFlashTop.sv
module norFlashTop
  import norFlashPkg::*;
#(
  parameter int ADDR_W         = 13,
  parameter int DATA_W         = 16,
  parameter int WORDS          = 64,
  parameter int SECTOR_WORDS   = 16,
  parameter int SECT_ERASE_CYC = 20,
  parameter int CHIP_ERASE_CYC = 40,
  parameter logic [DATA_W-1:0] ID_MFR  = 'h0001,
  parameter logic [DATA_W-1:0] ID_DEV  = 'h227E,
  parameter logic [DATA_W-1:0] ID_EXT0 = 'h2210,
  parameter logic [DATA_W-1:0] ID_EXT1 = 'h2201,
  parameter bit  EXT_ID_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);
  localparam int SHIFT = $clog2(DATA_W / 8);
  localparam int WA_W  = ADDR_W - SHIFT;
  localparam int IDX_W = $clog2(WORDS);

  logic [WA_W-1:0] wa;
  dpCtl_t          ctl;

  assign wa = addr[ADDR_W-1:SHIFT];

  generate
    if (SHIFT > 0) begin : g_lowBits
      logic unusedLowBits;
      assign unusedLowBits = ^addr[SHIFT-1:0];
    end
  endgenerate

  norFlashCtrl #(
    .WA_W(WA_W), .SECT_ERASE_CYC(SECT_ERASE_CYC), .CHIP_ERASE_CYC(CHIP_ERASE_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wa(wa), .cmdByte(wrData[7:0]),
    .ctl(ctl), .busy(busy)
  );

  norFlashData #(
    .DATA_W(DATA_W), .WORDS(WORDS), .SECTOR_WORDS(SECTOR_WORDS),
    .ID_MFR(ID_MFR), .ID_DEV(ID_DEV), .ID_EXT0(ID_EXT0), .ID_EXT1(ID_EXT1),
    .EXT_ID_EN(EXT_ID_EN)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdEn(rdEn),
    .arrIdx(wa[IDX_W-1:0]), .regOff(wa[7:0]), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/sim_norFlashTop.sv
`timescale 1ns/1ps
module sim_norFlashTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [12:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busy;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        rdFire = 1'b0;
  int          busyRun = 0;
  int          lastBusyLen = 0;

  always #5 clk = ~clk;

  norFlashTop u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: reads are due one cycle after the strobe
  always @(posedge clk) rdFire <= rdEn;
  always @(negedge clk) begin
    if (rdFire) begin
      if (expQ.size() == 0) chk(1'b0, "scoreboard-empty", int'(rdData), 0);
      else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rdData === e, t, int'(rdData), int'(e));
      end
    end
    if (busy) busyRun++;
    else if (busyRun != 0) begin lastBusyLen = busyRun; busyRun = 0; end
  end

  task automatic wr(input logic [12:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic unlock();
    wr(13'hAAA, 16'h00AA);
    wr(13'h554, 16'h0055);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    rd(13'h000, 16'hFFFF, "R1 word0");
    rd(13'h07E, 16'hFFFF, "R1 word63");

    // R3 program AND
    unlock(); wr(13'hAAA, 16'h00A0); wr(13'h00A, 16'h12F0);
    rd(13'h00A, 16'h12F0, "R3 first program");
    unlock(); wr(13'hAAA, 16'h00A0); wr(13'h00A, 16'h0F3C);
    rd(13'h00A, 16'h0230, "R3 AND program");
    // R10 status after a program with bit7 clear, read while program pending
    unlock(); wr(13'hAAA, 16'h00A0);
    rd(13'h000, 16'h00FF, "R10 status bit7 clear data");
    rd(13'h000, 16'h00BF, "R9 status bit6 toggles");
    wr(13'h00C, 16'h0080);
    rd(13'h00C, 16'h0080, "R3 word6");
    unlock(); wr(13'hAAA, 16'h00A0);
    rd(13'h000, 16'h007F, "R10 status bit7 set data");
    wr(13'h00C, 16'hFFFF);

    // R2 broken unlocks
    wr(13'hAAA, 16'h00AA); wr(13'h556, 16'h0055); wr(13'hAAA, 16'h00A0); wr(13'h010, 16'h0000);
    rd(13'h010, 16'hFFFF, "R2 bad second address");
    wr(13'hAAA, 16'h00AB); wr(13'h554, 16'h0055); wr(13'hAAA, 16'h00A0); wr(13'h010, 16'h0000);
    rd(13'h010, 16'hFFFF, "R2 bad first data");

    // R4 autoselect
    unlock(); wr(13'hAAA, 16'h0090);
    rd(13'h000, 16'h0001, "R4 id0");
    rd(13'h002, 16'h227E, "R4 id1");
    rd(13'h004, 16'h0000, "R4 protect word");
    rd(13'h01C, 16'h2210, "R4 ext id0");
    rd(13'h01E, 16'h2201, "R4 ext id1");
    rd(13'h00A, 16'h0230, "R4 other offset array");
    wr(13'h000, 16'h00F0);
    rd(13'h000, 16'hFFFF, "R6 F0 leaves autoselect");

    // R5 query mode
    wr(13'h0AA, 16'h0098);
    rd(13'h020, 16'h0051, "R5 Q");
    rd(13'h022, 16'h0052, "R5 R");
    rd(13'h024, 16'h0059, "R5 Y");
    rd(13'h026, 16'h0002, "R5 cmd set");
    rd(13'h04E, 16'h0007, "R5 size");
    rd(13'h080, 16'h0000, "R5 beyond length");
    wr(13'h000, 16'h0000);
    rd(13'h020, 16'hFFFF, "R5 write exits query");
    unlock(); wr(13'hAAA, 16'h0090); wr(13'h0AA, 16'h0098);
    rd(13'h022, 16'h0052, "R5 query from autoselect");
    wr(13'h000, 16'h00F0);

    // R6 F0 as program data, and F0 aborting an unlock
    unlock(); wr(13'hAAA, 16'h00A0); wr(13'h00E, 16'h00F0);
    rd(13'h00E, 16'h00F0, "R6 F0 programmed");
    wr(13'hAAA, 16'h00AA); wr(13'h000, 16'h00F0); wr(13'h554, 16'h0055);
    wr(13'hAAA, 16'h00A0); wr(13'h012, 16'h0000);
    rd(13'h012, 16'hFFFF, "R6 F0 aborts unlock");

    // R7 sector erase with R9 status polling
    unlock(); wr(13'hAAA, 16'h00A0); wr(13'h028, 16'h1234);
    unlock(); wr(13'hAAA, 16'h0080); unlock(); wr(13'h006, 16'h0030);
    chk(busy == 1'b1, "R7 busy after sector erase", int'(busy), 1);
    rd(13'h000, 16'h0000, "R9 status cleared");
    rd(13'h000, 16'h0040, "R9 toggle1");
    wr(13'h000, 16'h00F0);
    rd(13'h000, 16'h0000, "R9 F0 ignored while busy");
    waitIdle();
    chk(lastBusyLen == 20, "R7 sector busy length", lastBusyLen, 20);
    rd(13'h006, 16'hFFFF, "R7 word3 erased");
    rd(13'h00A, 16'hFFFF, "R7 word5 erased");
    rd(13'h00E, 16'hFFFF, "R7 word7 erased");
    rd(13'h028, 16'h1234, "R7 other sector kept");
    unlock(); wr(13'hAAA, 16'h00A0);
    rd(13'h000, 16'h00C0, "R9 bit7 flipped at completion");
    wr(13'h02A, 16'hFFFF);

    // R8 chip erase, wrong address first
    unlock(); wr(13'hAAA, 16'h0080); unlock(); wr(13'h000, 16'h0010);
    chk(busy == 1'b0, "R8 misplaced chip erase", int'(busy), 0);
    rd(13'h028, 16'h1234, "R8 no erase on bad address");
    unlock(); wr(13'hAAA, 16'h0080); unlock(); wr(13'hAAA, 16'h0010);
    waitIdle();
    chk(lastBusyLen == 40, "R8 chip busy length", lastBusyLen, 40);
    rd(13'h028, 16'hFFFF, "R8 word20 erased");

    // R11 bypass
    unlock(); wr(13'hAAA, 16'h0020);
    wr(13'h000, 16'h00A0); wr(13'h030, 16'h5555);
    wr(13'h100, 16'h00A0); wr(13'h032, 16'hAAAA);
    rd(13'h030, 16'h5555, "R11 bypass program a");
    rd(13'h032, 16'hAAAA, "R11 bypass program b");
    wr(13'h000, 16'h0080); unlock(); wr(13'h030, 16'h0030);
    waitIdle();
    wr(13'h000, 16'h00A0); wr(13'h034, 16'h0F0F);
    rd(13'h034, 16'h0F0F, "R11 bypass kept after erase");
    rd(13'h030, 16'hFFFF, "R11 bypass sector erase");
    wr(13'h000, 16'h0090); wr(13'h000, 16'h0000);
    wr(13'h000, 16'h00A0); wr(13'h036, 16'h0000);
    rd(13'h036, 16'hFFFF, "R11 bypass exited");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule